// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

This block is a down-counter that is advanced by a time-base tick enable rather than by every clock. Software loads a starting count through a small register port; each qualified tick lowers the count by one. When the count steps from one to zero the block records an expiry event in a sticky status flag. The block can optionally restart itself from a separate reload register at that moment. Without that option it parks at zero.

The interrupt line is the AND of the sticky status flag and an enable bit. Software acknowledges an event by writing a one to the status flag. Enabling the interrupt while an event is already pending raises the line immediately. The counter never wraps below zero. Loading a value with the top bit set is treated as an ordinary large count and causes no event.

Top module: `autodec_timer`

## Requirements
- R1: After synchronous reset, the count, reload, control and status registers all read zero and `irq` is low.
- R2: In each cycle with `tick` high and no count write, a nonzero count drops by exactly one; with `tick` low the count holds.
- R3: A tick that moves the count from 1 to 0 sets the status flag (status register bit 0) in the next cycle.
- R4: Without auto-reload the count stays at 0 after expiry and further ticks raise no new event until software writes a new count.
- R5: With auto-reload enabled (control bit 1), the tick that ends a count loads the count from the reload register (address 1) instead of 0, and still sets the status flag.
- R6: `irq` is high exactly while the status flag and the interrupt enable (control bit 0) are both set; setting the enable while the flag is already set raises `irq` in the next cycle.
- R7: Writing the status register (address 3) with bit 0 set clears the flag and drops `irq`; writing it with bit 0 clear leaves the flag unchanged.
- R8: Writing the count register (address 0) with any value, including one with bit 31 set, sets no status flag and raises no interrupt; the count reads back the written value.
- R9: When an expiry and a status clear fall in the same cycle, the flag stays set.
- R10: A count write in the same cycle as a tick loads the written value without decrementing it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base tick enable; one count step per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 count, 1 reload, 2 control, 3 status |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data of the register selected by `addr` (combinational) |
| irq | output | 1 | Interrupt: status flag AND interrupt enable |

## Verification
The bench pushes the count through the one-to-zero step with and without auto-reload. A design that wrapped to all-ones or fired repeatedly at zero would show a nonzero count or a status flag that comes back after clearing. It enables the interrupt over an already pending flag, which a design that raised `irq` only at the moment of expiry would miss. It also issues a clear in the very cycle of expiry, where a design giving the clear priority would lose the event. It loads a count with bit 31 set and writes a count during a tick, which catch a design that applies a sign-change rule or lets the decrement override the load.

// File: rtl/autodec_pkg.sv
package autodec_pkg;

    // Register select codes on the 2-bit address port
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_RELOAD = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    // Field positions inside control and status words
    localparam int CTRL_IRQ_EN_BIT = 0;
    localparam int CTRL_RELOAD_BIT = 1;
    localparam int STS_EXPIRED_BIT = 0;

    typedef struct packed {
        logic reload_en;
        logic irq_en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_bits(input logic irq_bit, input logic reload_bit);
        ctrl_t c;
        c.irq_en    = irq_bit;
        c.reload_en = reload_bit;
        return c;
    endfunction

endpackage

// File: rtl/autodec_counter.sv
module autodec_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             reload_en,
    input  logic [CNT_W-1:0] reload_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic at_one;
    logic at_zero;

    assign at_one  = (cnt_q == ONE);
    assign at_zero = (cnt_q == ZERO);
    assign expire  = tick && !load && at_one;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= ZERO;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && !at_zero) begin
            if (at_one) begin
                cnt_q <= reload_en ? reload_val : ZERO;
            end else begin
                cnt_q <= cnt_q - ONE;
            end
        end
    end

    // R2: one step per tick above one
    assert_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R4: a parked zero stays parked without a write
    assert_park_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (at_zero && !load) |=> (cnt_q == ZERO));

    // R5: expiry with reload enabled restarts from the reload value
    assert_reload_R5: assert property (@(posedge clk) disable iff (rst)
        (expire && reload_en) |=> (cnt_q == $past(reload_val)));

    // R10: a write always wins over a tick
    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/autodec_regs.sv
module autodec_regs
    import autodec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [CNT_W-1:0] wdata,
    input  logic             expire,
    output logic             cnt_load,
    output logic [CNT_W-1:0] reload_q,
    output ctrl_t            ctrl_q,
    output logic             sts_q
);
    logic sts_clr;

    assign cnt_load = wr_en && (sel == SEL_COUNT);
    assign sts_clr  = wr_en && (sel == SEL_STATUS) && wdata[STS_EXPIRED_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            ctrl_q   <= '0;
            sts_q    <= 1'b0;
        end else begin
            if (wr_en && sel == SEL_RELOAD) begin
                reload_q <= wdata;
            end
            if (wr_en && sel == SEL_CTRL) begin
                ctrl_q <= ctrl_from_bits(wdata[CTRL_IRQ_EN_BIT], wdata[CTRL_RELOAD_BIT]);
            end
            // a fresh event outranks a clear in the same cycle
            sts_q <= (sts_q && !sts_clr) || expire;
        end
    end

    // R3 and R9: every expiry leaves the flag set
    assert_expiry_sets_R3: assert property (@(posedge clk) disable iff (rst)
        expire |=> sts_q);

    // R7: a one written to the flag clears it when no event competes
    assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
        (sts_clr && !expire) |=> !sts_q);

    // R7: without clear or event the flag holds
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!sts_clr && !expire) |=> (sts_q == $past(sts_q)));

endmodule

// File: rtl/autodec_timer.sv
module autodec_timer
    import autodec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] rdata,
    output logic             irq
);
    reg_sel_e         sel;
    logic             cnt_load;
    logic             expire;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    ctrl_t            ctrl_q;
    logic             sts_q;

    assign sel = reg_sel_e'(addr);

    autodec_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .sel      (sel),
        .wdata    (wdata),
        .expire   (expire),
        .cnt_load (cnt_load),
        .reload_q (reload_q),
        .ctrl_q   (ctrl_q),
        .sts_q    (sts_q)
    );

    autodec_counter #(.CNT_W(CNT_W)) u_counter (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .load       (cnt_load),
        .load_val   (wdata),
        .reload_en  (ctrl_q.reload_en),
        .reload_val (reload_q),
        .cnt_q      (cnt_q),
        .expire     (expire)
    );

    assign irq = sts_q && ctrl_q.irq_en;

    always_comb begin
        rdata = '0;
        unique case (sel)
            SEL_COUNT:  rdata = cnt_q;
            SEL_RELOAD: rdata = reload_q;
            SEL_CTRL: begin
                rdata[CTRL_IRQ_EN_BIT] = ctrl_q.irq_en;
                rdata[CTRL_RELOAD_BIT] = ctrl_q.reload_en;
            end
            SEL_STATUS: rdata[STS_EXPIRED_BIT] = sts_q;
            default:    rdata = '0;
        endcase
    end

    // R6: enabling over a pending flag raises the line at once
    assert_late_enable_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_CTRL && wdata[CTRL_IRQ_EN_BIT] && sts_q) |=> irq);

    // R8: a count write never raises the line by itself
    assert_load_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (cnt_load && !irq) |=> !irq);

    // R1: clean state right after reset
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (!irq && cnt_q == '0 && !sts_q));

endmodule

// File: tb/autodec_timer_bench.sv
`timescale 1ns/1ps
module autodec_timer_bench;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tick = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   addr = 2'd0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;
    logic [32:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    autodec_timer #(.CNT_W(W)) u_autodec_timer (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    task automatic drive(input logic we, input logic [1:0] a, input logic [W-1:0] d, input logic t);
        @(negedge clk);
        wr_en = we;
        addr  = a;
        wdata = d;
        tick  = t;
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        drive(1'b1, a, d, 1'b0);
    endtask

    task automatic idle(input int n, input logic t);
        for (int i = 0; i < n; i++) drive(1'b0, addr, '0, t);
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [W-1:0] e, input string tag);
        drive(1'b0, a, '0, 1'b0);
        exp_q.push_back({1'b0, e});
        tag_q.push_back(tag);
    endtask

    task automatic expect_irq(input logic e, input string tag);
        drive(1'b0, addr, '0, 1'b0);
        exp_q.push_back({1'b1, 31'd0, e});
        tag_q.push_back(tag);
    endtask

    // monitor: compares outputs one step after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                logic [32:0]  e;
                string        t;
                logic [W-1:0] act;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                act = e[32] ? {31'd0, irq} : rdata;
                checks++;
                if (act !== e[31:0]) begin
                    errors++;
                    $display("FAIL %s actual %h expected %h", t, act, e[31:0]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (R1 sequence hung)");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_reg(2'd0, 32'd0, "R1 count");
        expect_reg(2'd1, 32'd0, "R1 reload");
        expect_reg(2'd2, 32'd0, "R1 ctrl");
        expect_reg(2'd3, 32'd0, "R1 status");
        expect_irq(1'b0, "R1 irq");
        // R2 decrement and hold
        wr(2'd0, 32'd5);
        expect_reg(2'd0, 32'd5, "R8 count readback");
        idle(2, 1'b1);
        expect_reg(2'd0, 32'd3, "R2 two ticks");
        idle(3, 1'b0);
        expect_reg(2'd0, 32'd3, "R2 hold without tick");
        // R3 expiry
        idle(3, 1'b1);
        expect_reg(2'd0, 32'd0, "R3 count at zero");
        expect_reg(2'd3, 32'd1, "R3 status set");
        expect_irq(1'b0, "R6 disabled irq");
        // R4 parked at zero
        idle(4, 1'b1);
        expect_reg(2'd0, 32'd0, "R4 stays zero");
        wr(2'd3, 32'd1);
        expect_reg(2'd3, 32'd0, "R7 clear");
        idle(3, 1'b1);
        expect_reg(2'd3, 32'd0, "R4 no new event");
        // R6 / R7 interrupt behaviour
        wr(2'd2, 32'd1);
        expect_irq(1'b0, "R6 enable without flag");
        wr(2'd0, 32'd2);
        idle(2, 1'b1);
        expect_irq(1'b1, "R6 irq on expiry");
        wr(2'd3, 32'd0);
        expect_reg(2'd3, 32'd1, "R7 zero write no effect");
        wr(2'd3, 32'd1);
        expect_irq(1'b0, "R7 irq dropped");
        expect_reg(2'd3, 32'd0, "R7 flag cleared");
        // R6 late enable
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd1);
        idle(1, 1'b1);
        expect_irq(1'b0, "R6 pending but disabled");
        expect_reg(2'd3, 32'd1, "R3 pending flag");
        wr(2'd2, 32'd1);
        expect_irq(1'b1, "R6 late enable");
        wr(2'd3, 32'd1);
        // R5 auto-reload
        wr(2'd2, 32'd3);
        expect_reg(2'd2, 32'd3, "R1 ctrl readback");
        wr(2'd1, 32'd4);
        wr(2'd0, 32'd1);
        idle(1, 1'b1);
        expect_reg(2'd0, 32'd4, "R5 reload on expiry");
        expect_reg(2'd3, 32'd1, "R5 flag on reload");
        wr(2'd3, 32'd1);
        idle(3, 1'b1);
        expect_reg(2'd0, 32'd1, "R5 counting after reload");
        expect_reg(2'd3, 32'd0, "R5 no early flag");
        idle(1, 1'b1);
        expect_reg(2'd0, 32'd4, "R5 second reload");
        expect_reg(2'd3, 32'd1, "R5 second flag");
        // R9 expiry beats clear
        wr(2'd2, 32'd1);
        wr(2'd3, 32'd1);
        wr(2'd0, 32'd1);
        drive(1'b1, 2'd3, 32'd1, 1'b1);
        expect_reg(2'd3, 32'd1, "R9 event wins over clear");
        expect_reg(2'd0, 32'd0, "R4 no reload when off");
        // R8 top-bit load
        wr(2'd3, 32'd1);
        expect_irq(1'b0, "R8 irq low before load");
        wr(2'd0, 32'h8000_0000);
        expect_irq(1'b0, "R8 no irq from load");
        expect_reg(2'd3, 32'd0, "R8 no flag from load");
        expect_reg(2'd0, 32'h8000_0000, "R8 count readback");
        idle(1, 1'b1);
        expect_reg(2'd0, 32'h7FFF_FFFF, "R2 step across top bit");
        expect_reg(2'd3, 32'd0, "R8 no flag after step");
        // R10 write beats tick
        wr(2'd0, 32'd10);
        drive(1'b1, 2'd0, 32'd7, 1'b1);
        expect_reg(2'd0, 32'd7, "R10 write wins over tick");
        idle(2, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule